// File: doc/BRIEF.md
# Delay-Locked Loop Setting Tracker

This block is the digital half of a delay-locked loop. On every reference-clock edge it reads a one-bit early/late decision from an external phase comparator. It then nudges a 7-bit delay code by one step toward phase alignment. That code drives a chain of up to eight delay elements. The code is held and stepped in Gray form, so the analog chain never sees more than one control bit change per update.

A registered binary copy of the code is offered to the fabric and to strobe phase-shift logic. A select input chooses between a 90° shifted strobe and a 0° strobe; the 0° strobe skips the loop delay through a bypass selector. A lock timer counts reference cycles from the end of any reset and raises a lock flag once the fixed acquisition window has elapsed.

Two reset sources are combined: one from internal logic and one from an external pin. Either of them restarts the loop at the midpoint code and restarts the lock window.

Top module: `dll_setting_ctrl`

## Requirements
- R1: While reset is active, and on the first cycle after it, `gray_set` equals 7'b1100000 (the Gray form of binary 64), `bin_set` equals 64 and `locked` is 0.
- R2: On each clock edge with `upd_en`=1 and no reset, the binary value of `gray_set` rises by one when `cmp_up`=1 and falls by one when `cmp_up`=0. The new value is visible after that edge.
- R3: Two successive values of `gray_set` outside reset differ in exactly one bit when the setting moves, and in no bit when it holds.
- R4: The setting saturates. An up request at binary 127 and a down request at binary 0 leave `gray_set` unchanged.
- R5: `bin_set` equals the binary value that `gray_set` held in the previous cycle. Binary bit i is the XOR of Gray bits 6 down to i.
- R6: While `upd_en`=0, `gray_set` holds its value whatever `cmp_up` does. The lock timer keeps counting.
- R7: After reset is released, `locked` stays 0 for 2560 clock edges and is 1 from the 2560th edge onward, until the next reset.
- R8: The block is reset when `rst_n` is 0 or `pin_rst_n` is 0 at a clock edge. A single cycle of either is enough to restart the setting and the lock window.
- R9: `bypass_sel` is 1 when `phase_90`=0 (0° shift, loop delay skipped) and 0 when `phase_90`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset from internal logic |
| pin_rst_n | input | 1 | Synchronous active-low reset from an external pin |
| upd_en | input | 1 | 1 lets the setting follow the comparator, 0 freezes it |
| cmp_up | input | 1 | Comparator decision: 1 adds delay, 0 removes delay |
| phase_90 | input | 1 | 1 selects the 90° shifted strobe, 0 selects 0° |
| gray_set | output | 7 | Gray-coded delay setting for the delay chain |
| bin_set | output | 7 | Registered binary copy of the setting |
| bypass_sel | output | 1 | 1 routes the strobe around the loop delay |
| locked | output | 1 | Lock acquisition window has elapsed |

## Verification
A wrong stepper state shows on `gray_set` right after the faulty edge. It appears as a value off the expected ramp, a multi-bit jump, or a wrap past 127 or 0. The bench walks the code across its full range in both directions and into both end stops to expose these. A broken binary mirror shows on `bin_set` one cycle later. A miscounting lock timer shows as `locked` rising one or more edges early or late; the bench checks the flag on every cycle of the window, so an error shows within that window.

// File: rtl/dll_ctrl_pkg.sv
// Package: shared width, code type and Gray/binary conversions for the
// delay-locked loop setting tracker. Assumes setting width of at least 2.
package dll_ctrl_pkg;

    localparam int SET_W = 7;
    typedef logic [SET_W-1:0] dset_t;

    localparam dset_t SET_MAX = '1;
    localparam dset_t SET_MIN = '0;

    // Binary to Gray: each bit XORs with its upper neighbour.
    function automatic dset_t to_gray(input dset_t b);
        return b ^ (b >> 1);
    endfunction

    // Gray to binary: running XOR from the most significant bit down.
    function automatic dset_t from_gray(input dset_t g);
        dset_t b;
        b[SET_W-1] = g[SET_W-1];
        for (int i = SET_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dll_gray_stepper.sv
// Module: dll_gray_stepper
// Holds the delay setting in Gray form and moves it one code per enabled
// cycle, up or down as the comparator decision asks, stopping at both ends.
// Assumes: rst_n is synchronous, active low, already combined from all sources.
module dll_gray_stepper
    import dll_ctrl_pkg::*;
#(
    parameter dset_t START_BIN = dset_t'(1 << (SET_W - 1))
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step_en,
    input  logic  step_up,
    output dset_t gray_q
);

    dset_t cur_bin;
    dset_t nxt_bin;
    logic  at_top;
    logic  at_bot;
    logic  move;

    // Decode present code and decide whether a step is allowed.
    always_comb begin
        cur_bin = from_gray(gray_q);
        at_top  = (cur_bin == SET_MAX);
        at_bot  = (cur_bin == SET_MIN);
        move    = step_en && (step_up ? !at_top : !at_bot);
        nxt_bin = step_up ? cur_bin + 1'b1 : cur_bin - 1'b1;
    end

    // Register the Gray code, loading the midpoint on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gray_q <= to_gray(START_BIN);
        end else if (move) begin
            gray_q <= to_gray(nxt_bin);
        end
    end

endmodule

// File: rtl/dll_lock_timer.sv
// Module: dll_lock_timer
// Counts reference edges after reset and flags lock once the window is done.
// Assumes: LOCK_CYCLES >= 1; the counter saturates, so the flag stays set.
module dll_lock_timer #(
    parameter int LOCK_CYCLES = 2560
) (
    input  logic clk,
    input  logic rst_n,
    output logic lock_o
);

    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES);

    logic [CW-1:0] cnt_q;

    // Advance the window counter until it reaches the lock count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Lock is declared exactly when the counter has reached its end.
    assign lock_o = (cnt_q == LAST);

endmodule

// File: rtl/dll_bin_mirror.sv
// Module: dll_bin_mirror
// Registers the binary equivalent of the Gray setting for fabric consumers.
// Assumes: one cycle of latency behind the Gray register is acceptable.
module dll_bin_mirror
    import dll_ctrl_pkg::*;
#(
    parameter dset_t START_BIN = dset_t'(1 << (SET_W - 1))
) (
    input  logic  clk,
    input  logic  rst_n,
    input  dset_t gray_i,
    output dset_t bin_q
);

    // Capture the decoded setting each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q <= START_BIN;
        end else begin
            bin_q <= from_gray(gray_i);
        end
    end

endmodule

// File: rtl/dll_setting_ctrl.sv
// Module: dll_setting_ctrl (top)
// Digital control loop of a delay-locked loop: merges the two reset sources,
// steps the Gray delay code from the comparator decision, mirrors it in
// binary, times lock acquisition and drives the 0-degree bypass select.
// Assumes: all inputs are synchronous to clk.
module dll_setting_ctrl
    import dll_ctrl_pkg::*;
#(
    parameter int LOCK_CYCLES = 2560
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_rst_n,
    input  logic        upd_en,
    input  logic        cmp_up,
    input  logic        phase_90,
    output logic [6:0]  gray_set,
    output logic [6:0]  bin_set,
    output logic        bypass_sel,
    output logic        locked
);

    localparam dset_t MID_BIN = dset_t'(1 << (SET_W - 1));

    logic  rst_all_n;
    dset_t gray_w;
    dset_t bin_w;

    // Either source holds the whole loop in reset.
    assign rst_all_n = rst_n & pin_rst_n;

    dll_gray_stepper #(.START_BIN(MID_BIN)) u_step (
        .clk     (clk),
        .rst_n   (rst_all_n),
        .step_en (upd_en),
        .step_up (cmp_up),
        .gray_q  (gray_w)
    );

    dll_bin_mirror #(.START_BIN(MID_BIN)) u_mirror (
        .clk    (clk),
        .rst_n  (rst_all_n),
        .gray_i (gray_w),
        .bin_q  (bin_w)
    );

    dll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_all_n),
        .lock_o (locked)
    );

    assign gray_set   = gray_w;
    assign bin_set    = bin_w;
    // Zero-degree selection routes the strobe around the loop delay.
    assign bypass_sel = !phase_90;

endmodule

// File: rtl/dll_setting_ctrl_chk.sv
// Module: dll_setting_ctrl_chk
// Property checker for dll_setting_ctrl, attached by bind below.
// Assumes: reset is asserted from time zero.
module dll_setting_ctrl_chk
    import dll_ctrl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pin_rst_n,
    input logic       upd_en,
    input logic       cmp_up,
    input logic [6:0] gray_set,
    input logic [6:0] bin_set,
    input logic       locked
);

    logic rst_ok;
    assign rst_ok = rst_n & pin_rst_n;

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_ok)
        ($past(rst_ok) && $past(upd_en) && $past(cmp_up) && $past(from_gray(gray_set)) != SET_MAX)
        |-> from_gray(gray_set) == $past(from_gray(gray_set)) + 7'd1); // R2

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_ok)
        ($past(rst_ok) && $past(upd_en) && !$past(cmp_up) && $past(from_gray(gray_set)) != SET_MIN)
        |-> from_gray(gray_set) == $past(from_gray(gray_set)) - 7'd1); // R2

    AST_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_ok)
        $past(rst_ok) |-> $countones(gray_set ^ $past(gray_set)) <= 1); // R3

    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_ok)
        ($past(rst_ok) && $past(from_gray(gray_set)) == SET_MAX) |-> from_gray(gray_set) != SET_MIN); // R4

    AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rst_ok)
        ($past(rst_ok) && $past(from_gray(gray_set)) == SET_MIN) |-> from_gray(gray_set) != SET_MAX); // R4

    AST_MIRROR_LAG: assert property (@(posedge clk) disable iff (!rst_ok)
        $past(rst_ok) |-> bin_set == from_gray($past(gray_set))); // R5

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_ok)
        ($past(rst_ok) && !$past(upd_en)) |-> $stable(gray_set)); // R6

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_ok)
        locked |=> locked); // R7

    AST_LOCK_CLEARS: assert property (@(posedge clk)
        !rst_ok |=> !locked); // R8

endmodule

bind dll_setting_ctrl dll_setting_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_rst_n (pin_rst_n),
    .upd_en    (upd_en),
    .cmp_up    (cmp_up),
    .gray_set  (gray_set),
    .bin_set   (bin_set),
    .locked    (locked)
);

// File: tb/sim_dll_setting_ctrl.sv
module sim_dll_setting_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_rst_n = 1'b1;
    logic       upd_en = 1'b0;
    logic       cmp_up = 1'b0;
    logic       phase_90 = 1'b1;
    logic [6:0] gray_set;
    logic [6:0] bin_set;
    logic       bypass_sel;
    logic       locked;

    int n_run = 0;
    int n_fail = 0;
    int ebin = 64;
    int lc = 0;
    logic [15:0] lf = 16'hACE1;

    always #10 clk = ~clk;

    dll_setting_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .upd_en(upd_en),
        .cmp_up(cmp_up), .phase_90(phase_90), .gray_set(gray_set),
        .bin_set(bin_set), .bypass_sel(bypass_sel), .locked(locked)
    );

    function automatic int gcode(input int b);
        return (b ^ (b >> 1)) & 127;
    endfunction

    function automatic int g2b(input logic [6:0] g);
        int b = 0;
        int acc = 0;
        for (int i = 6; i >= 0; i--) begin
            acc = acc ^ int'(g[i]);
            b = b | (acc << i);
        end
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One enabled-or-frozen clock step with full checking after the edge.
    task automatic step(input bit up, input bit en);
        int prev_bin_exp;
        int old;
        logic [6:0] prev_gray;
        prev_bin_exp = ebin;
        old = ebin;
        prev_gray = gray_set;
        cmp_up = up;
        upd_en = en;
        if (en) begin
            if (up && ebin < 127) ebin++;
            else if (!up && ebin > 0) ebin--;
        end
        @(posedge clk);
        @(negedge clk);
        lc++;
        chk(int'(gray_set) == gcode(ebin), "R2/R4/R6 gray", int'(gray_set), gcode(ebin));
        chk(int'(bin_set) == prev_bin_exp, "R5 bin lag", int'(bin_set), prev_bin_exp);
        chk($countones(gray_set ^ prev_gray) == ((old != ebin) ? 1 : 0), "R3 bit changes",
            $countones(gray_set ^ prev_gray), (old != ebin) ? 1 : 0);
        chk(locked == (lc >= 2560), "R7 lock", int'(locked), int'(lc >= 2560));
    endtask

    // Hold one reset source low for ncyc edges, then check the reset state.
    task automatic do_reset(input bit use_pin, input int ncyc);
        if (use_pin) pin_rst_n = 1'b0; else rst_n = 1'b0;
        upd_en = 1'b1;
        cmp_up = 1'b1;
        repeat (ncyc) @(posedge clk);
        @(negedge clk);
        chk(int'(gray_set) == 96, "R1/R8 gray reset", int'(gray_set), 96);
        chk(int'(bin_set) == 64, "R1/R8 bin reset", int'(bin_set), 64);
        chk(locked == 1'b0, "R1/R8 lock reset", int'(locked), 0);
        rst_n = 1'b1;
        pin_rst_n = 1'b1;
        ebin = 64;
        lc = 0;
    endtask

    task automatic rnd_steps(input int n);
        for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], lf[3] | lf[5]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int target;
        // R9 bypass select both ways
        phase_90 = 1'b0; #1;
        chk(bypass_sel == 1'b1, "R9 bypass at 0deg", int'(bypass_sel), 1);
        phase_90 = 1'b1; #1;
        chk(bypass_sel == 1'b0, "R9 bypass at 90deg", int'(bypass_sel), 0);
        @(negedge clk);
        do_reset(1'b0, 3);                        // R1 via internal source
        for (int i = 0; i < 70; i++) step(1'b1, 1'b1);   // ramp into top stop, R4
        for (int i = 0; i < 140; i++) step(1'b0, 1'b1);  // full ramp to bottom stop, R4
        for (int i = 0; i < 20; i++) step(i[0], 1'b0);   // frozen, R6
        for (int i = 0; i < 40; i++) step(i[0], 1'b1);   // dither
        rnd_steps(600);
        // Closed loop with a behavioural chain: eight cells, delay grows with code.
        target = 83;
        for (int i = 0; i < 120; i++) step((8 * (g2b(gray_set) + 1)) < (8 * (target + 1)), 1'b1);
        chk(ebin == target || ebin == target - 1, "R2 closed loop settles", ebin, target);
        while (lc < 2600) rnd_steps(1);           // R7 across the lock edge
        do_reset(1'b1, 1);                        // R8 single-cycle pin reset
        for (int i = 0; i < 2600; i++) step(i[1], 1'b1);
        rnd_steps(50);
        do_reset(1'b0, 1);                        // R8 single-cycle internal reset
        rnd_steps(2570);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule